// File: doc/BRIEF.md
# Receive Queue with Per-Character Error Tags and Line Status

This block sits between a serial receiver and a CPU-style register interface. Each time the receiver completes a character it presents the byte together with three error tags: parity, framing and break. The block stores byte and tags together as one queue entry. The CPU sees the byte at the head of the queue through a data port and reads the receiver condition through a line status byte.

The parity, framing and break bits of the status byte are not reported when a character is stored. Each tag is reported only when its own character becomes the head of the queue, and it then stays visible until the next status read. The block also keeps a sticky summary bit that stays set while any tagged character is still queued. A status read clears that bit only when no tagged character remains. A character that arrives when the queue has no room raises an overrun flag and is discarded.

A mode input selects between two capacities. In queued mode the block holds the full parameterised depth. In single-holding mode it holds one character and forces the summary bit to zero. A line-status interrupt request is raised while it is enabled and any of the four error conditions is set.

Top module: `rx_tagged_fifo`

## Requirements
- R1: Status bit 0 is 1 exactly when at least one character is queued, and status bits 5 and 6 always read 0. `data_out` shows the head byte, or 0x00 when the queue is empty. A pulse on `rd_data_stb` removes the head entry, and the pulse has no effect when the queue is empty.
- R2: In queued mode (`fifo_en`=1) the block holds 16 characters (parameter DEPTH) and returns them in arrival order. In single-holding mode (`fifo_en`=0) it holds one character.
- R3: A character that arrives when the queue has no room is discarded, and status bit 1 (overrun) reads 1 from the next cycle on. When a removal and an arrival fall in the same cycle on a full queue, both take effect and no overrun is flagged.
- R4: A pulse on `rd_status_stb` returns the current status in that same cycle. From the next cycle, status bits 1 to 4 read 0 unless a new condition sets them in that cycle.
- R5: Tag inputs map to status bits as follows: parity to bit 2, framing to bit 3, break to bit 4. A tag reaches its status bit in the cycle after its character becomes the head of the queue, and it stays set until a status read. If the character becomes the head in the same cycle as a status read, the bit ends up set.
- R6: In queued mode, status bit 7 is 1 while any queued character carries a tag. After the last tagged character leaves, bit 7 stays 1 until a status read clears it. In single-holding mode bit 7 reads 0.
- R7: `lsi_irq` is 1 exactly when `lsi_en` is 1 and at least one of status bits 1 to 4 is 1.
- R8: After a synchronous reset the queue is empty, the status byte is 0x00, `data_out` is 0x00 and `lsi_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_en | input | 1 | 1 = queued mode, 0 = single-holding mode |
| lsi_en | input | 1 | Line-status interrupt enable |
| rx_valid | input | 1 | One-cycle strobe: receiver completed a character |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error tag of the character |
| rx_ferr | input | 1 | Framing error tag of the character |
| rx_brk | input | 1 | Break tag of the character |
| rd_data_stb | input | 1 | CPU data read; removes the head entry |
| rd_status_stb | input | 1 | CPU status read; clears the error flags |
| data_out | output | 8 | Head byte, or 0x00 when empty |
| status_out | output | 8 | Line status byte |
| lsi_irq | output | 1 | Line-status interrupt request |

## Verification
Two pairs of actions can land on the same edge. A removal can meet an arrival while the queue is full. A status read can meet a removal that promotes a tagged character to the head. The bench provokes both by raising the two strobes in the same cycle. For the first pair it checks that the overrun flag stays clear, then drains the queue to confirm that the last arrival was kept and the oldest entry was dropped. For the second pair it checks that the status read in that cycle returns the old value and that the new head's tag is still set afterwards.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int DATA_W = 8;

    // Status byte field positions
    localparam int LSR_DR   = 0;
    localparam int LSR_OE   = 1;
    localparam int LSR_PE   = 2;
    localparam int LSR_FE   = 3;
    localparam int LSR_BI   = 4;
    localparam int LSR_ESUM = 7;

    typedef struct packed {
        logic brk;
        logic ferr;
        logic perr;
    } rx_tags_t;

    typedef struct packed {
        rx_tags_t            tags;
        logic [DATA_W-1:0]   data;
    } rx_entry_t;

    function automatic logic has_tag(input rx_tags_t t);
        return t.brk | t.ferr | t.perr;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PTR_W = 4,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  rx_entry_t        wr_entry,
    input  logic             pop,
    output rx_entry_t        head,
    output rx_entry_t        second,
    output logic [CNT_W-1:0] count,
    output logic             tags_left_nx
);

    rx_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W-1:0] wr_ptr_nx, rd_ptr_nx;
    logic [CNT_W-1:0] tag_cnt, tag_cnt_nx;

    // Pointer advance: free wrap for power-of-two depths, compare otherwise
    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wr_ptr_nx = wr_ptr + PTR_W'(1);
            assign rd_ptr_nx = rd_ptr + PTR_W'(1);
        end else begin : g_wrap
            assign wr_ptr_nx = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            assign rd_ptr_nx = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
        end
    endgenerate

    assign head   = mem[rd_ptr];
    assign second = mem[rd_ptr_nx];

    always_comb begin
        tag_cnt_nx = tag_cnt;
        if (push && has_tag(wr_entry.tags)) tag_cnt_nx = tag_cnt_nx + CNT_W'(1);
        if (pop  && has_tag(head.tags))     tag_cnt_nx = tag_cnt_nx - CNT_W'(1);
    end

    assign tags_left_nx = (tag_cnt_nx != '0);

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            tag_cnt <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr_nx;
            if (pop)  rd_ptr <= rd_ptr_nx;
            case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
            tag_cnt <= tag_cnt_nx;
        end
    end

endmodule

// File: rtl/rxq_line_status.sv
module rxq_line_status
    import rxq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fifo_en,
    input  logic        irq_en,
    input  logic        data_ready,
    input  logic        head_load,
    input  rx_tags_t    head_tags,
    input  logic        ovr_evt,
    input  logic        status_rd,
    input  logic        tags_left_nx,
    output logic [7:0]  status_byte,
    output logic        irq
);

    logic oe_q, pe_q, fe_q, bi_q, esum_q;

    // A new condition in the same cycle as a status read takes priority
    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q   <= 1'b0;
            pe_q   <= 1'b0;
            fe_q   <= 1'b0;
            bi_q   <= 1'b0;
            esum_q <= 1'b0;
        end else begin
            if (ovr_evt)                        oe_q <= 1'b1;
            else if (status_rd)                 oe_q <= 1'b0;
            if (head_load && head_tags.perr)    pe_q <= 1'b1;
            else if (status_rd)                 pe_q <= 1'b0;
            if (head_load && head_tags.ferr)    fe_q <= 1'b1;
            else if (status_rd)                 fe_q <= 1'b0;
            if (head_load && head_tags.brk)     bi_q <= 1'b1;
            else if (status_rd)                 bi_q <= 1'b0;
            if (tags_left_nx)                   esum_q <= 1'b1;
            else if (status_rd)                 esum_q <= 1'b0;
        end
    end

    always_comb begin
        status_byte           = '0;
        status_byte[LSR_DR]   = data_ready;
        status_byte[LSR_OE]   = oe_q;
        status_byte[LSR_PE]   = pe_q;
        status_byte[LSR_FE]   = fe_q;
        status_byte[LSR_BI]   = bi_q;
        status_byte[LSR_ESUM] = fifo_en & esum_q;
    end

    assign irq = irq_en & (oe_q | pe_q | fe_q | bi_q);

endmodule

// File: rtl/rx_tagged_fifo.sv
module rx_tagged_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_en,
    input  logic              lsi_en,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_brk,
    input  logic              rd_data_stb,
    input  logic              rd_status_stb,
    output logic [DATA_W-1:0] data_out,
    output logic [7:0]        status_out,
    output logic              lsi_irq
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    rx_entry_t        in_entry, head, second;
    logic [CNT_W-1:0] count, cap;
    logic             empty, pop_ok, room, push_ok, ovr_evt;
    logic             empty_after_pop, head_load, tags_left_nx;
    rx_tags_t         head_tags;

    assign in_entry.data      = rx_data;
    assign in_entry.tags.perr = rx_perr;
    assign in_entry.tags.ferr = rx_ferr;
    assign in_entry.tags.brk  = rx_brk;

    assign cap     = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
    assign empty   = (count == '0);
    assign pop_ok  = rd_data_stb & ~empty;
    assign room    = (count < cap) | pop_ok;
    assign push_ok = rx_valid & room;
    assign ovr_evt = rx_valid & ~room;

    // Which entry (if any) becomes the head at this edge
    assign empty_after_pop = empty | (pop_ok & (count == CNT_W'(1)));

    always_comb begin
        head_load = 1'b0;
        head_tags = '0;
        if (pop_ok && !empty_after_pop) begin
            head_load = 1'b1;
            head_tags = second.tags;
        end else if (push_ok && empty_after_pop) begin
            head_load = 1'b1;
            head_tags = in_entry.tags;
        end
    end

    rxq_store #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W),
        .CNT_W (CNT_W)
    ) i_store (
        .clk          (clk),
        .rst          (rst),
        .push         (push_ok),
        .wr_entry     (in_entry),
        .pop          (pop_ok),
        .head         (head),
        .second       (second),
        .count        (count),
        .tags_left_nx (tags_left_nx)
    );

    rxq_line_status i_status (
        .clk          (clk),
        .rst          (rst),
        .fifo_en      (fifo_en),
        .irq_en       (lsi_en),
        .data_ready   (~empty),
        .head_load    (head_load),
        .head_tags    (head_tags),
        .ovr_evt      (ovr_evt),
        .status_rd    (rd_status_stb),
        .tags_left_nx (tags_left_nx),
        .status_byte  (status_out),
        .irq          (lsi_irq)
    );

    assign data_out = empty ? '0 : head.data;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_en,
    input logic             lsi_en,
    input logic             rx_valid,
    input logic             rd_data_stb,
    input logic             rd_status_stb,
    input logic [7:0]       status_out,
    input logic             lsi_irq,
    input logic [CNT_W-1:0] count
);

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    assert_ready_after_char_R1: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> status_out[0]);

    assert_overrun_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && fifo_en && count == CNT_W'(DEPTH) && !rd_data_stb) |=> status_out[1]);

    assert_overrun_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_status_stb && !rx_valid) |=> !status_out[1]);

    assert_tags_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_status_stb && !rx_valid && !rd_data_stb) |=> (status_out[4:2] == 3'b000));

    assert_summary_single_R6: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |-> !status_out[7]);

    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
        !lsi_en |-> !lsi_irq);

    assert_irq_overrun_R7: assert property (@(posedge clk) disable iff (rst)
        (lsi_en && status_out[1]) |-> lsi_irq);

endmodule

bind rx_tagged_fifo rxq_checker #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) i_rxq_checker (
    .clk           (clk),
    .rst           (rst),
    .fifo_en       (fifo_en),
    .lsi_en        (lsi_en),
    .rx_valid      (rx_valid),
    .rd_data_stb   (rd_data_stb),
    .rd_status_stb (rd_status_stb),
    .status_out    (status_out),
    .lsi_irq       (lsi_irq),
    .count         (count)
);

// File: tb/test_rx_tagged_fifo.sv
`timescale 1ns/1ps
module test_rx_tagged_fifo;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_en = 1'b1;
    logic       lsi_en = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
    logic       rd_data_stb = 1'b0, rd_status_stb = 1'b0;
    logic [7:0] data_out, status_out;
    logic       lsi_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rx_tagged_fifo #(.DEPTH(DEPTH)) i_rx_tagged_fifo (
        .clk, .rst, .fifo_en, .lsi_en, .rx_valid, .rx_data,
        .rx_perr, .rx_ferr, .rx_brk, .rd_data_stb, .rd_status_stb,
        .data_out, .status_out, .lsi_irq
    );

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 37 + seed) & 8'hFF);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    // tags = {brk, ferr, perr}
    task automatic push(input logic [7:0] d, input logic [2:0] tags);
        rx_valid = 1'b1; rx_data = d;
        {rx_brk, rx_ferr, rx_perr} = tags;
        cyc();
        rx_valid = 1'b0; {rx_brk, rx_ferr, rx_perr} = 3'b000;
    endtask

    task automatic pop();
        rd_data_stb = 1'b1; cyc(); rd_data_stb = 1'b0;
    endtask

    task automatic status_read(input string req, input int exp_during);
        rd_status_stb = 1'b1;
        #1;
        check(req, "status in read cycle", status_out, exp_during);
        cyc();
        rd_status_stb = 1'b0;
    endtask

    task automatic do_reset(input logic mode);
        rst = 1'b1; fifo_en = mode;
        cyc(); cyc();
        rst = 1'b0;
        cyc();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stim
        do_reset(1'b1);
        // R8: reset state
        check("R8", "status after reset", status_out, 8'h00);
        check("R8", "data after reset", data_out, 8'h00);
        check("R8", "irq after reset", lsi_irq, 0);

        // R2/R3: fill, overflow, then drain in order
        for (int i = 0; i < DEPTH; i++) push(pat(i, 5), 3'b000);
        check("R1", "status when full", status_out, 8'h01);
        push(8'hAA, 3'b000);
        check("R3", "overrun flag", status_out, 8'h03);
        check("R7", "irq on overrun", lsi_irq, 1);
        status_read("R4", 8'h03);
        check("R4", "status after read", status_out, 8'h01);
        check("R7", "irq after clear", lsi_irq, 0);
        for (int i = 0; i < DEPTH; i++) begin
            check("R2", "drain order", data_out, pat(i, 5));
            pop();
        end
        check("R1", "status when empty", status_out, 8'h00);
        check("R1", "data when empty", data_out, 8'h00);
        pop();
        check("R1", "pop on empty ignored", status_out, 8'h00);
        push(8'h3C, 3'b000);
        check("R1", "head after empty pop", data_out, 8'h3C);
        pop();

        // R3: removal and arrival in the same cycle on a full queue
        for (int i = 0; i < DEPTH; i++) push(pat(i, 9), 3'b000);
        rd_data_stb = 1'b1; rx_valid = 1'b1; rx_data = 8'h5C;
        cyc();
        rd_data_stb = 1'b0; rx_valid = 1'b0;
        check("R3", "no overrun on pop+push", status_out, 8'h01);
        for (int i = 1; i < DEPTH; i++) begin
            check("R3", "order after pop+push", data_out, pat(i, 9));
            pop();
        end
        check("R3", "kept arrival", data_out, 8'h5C);
        pop();
        check("R3", "empty after drain", status_out, 8'h00);

        // R5/R6/R7: tags appear as each character reaches the head
        push(8'h11, 3'b000);
        push(8'h22, 3'b001);
        push(8'h33, 3'b010);
        push(8'h44, 3'b100);
        check("R6", "summary set, head clean", status_out, 8'h81);
        check("R7", "no irq for queued tags", lsi_irq, 0);
        status_read("R6", 8'h81);
        check("R6", "summary kept while tagged queued", status_out, 8'h81);
        pop();
        check("R5", "parity at head", status_out, 8'h85);
        check("R5", "head byte", data_out, 8'h22);
        check("R7", "irq on parity", lsi_irq, 1);
        status_read("R4", 8'h85);
        check("R4", "parity cleared", status_out, 8'h81);
        pop();
        check("R5", "framing at head", status_out, 8'h89);
        pop();
        check("R5", "break at head, framing sticky", status_out, 8'h99);
        pop();
        check("R6", "summary sticky when empty", status_out, 8'h98);
        lsi_en = 1'b0;
        #1;
        check("R7", "irq masked", lsi_irq, 0);
        lsi_en = 1'b1;
        status_read("R6", 8'h98);
        check("R6", "summary cleared", status_out, 8'h00);

        // R5: status read in the same cycle a tagged entry becomes head
        push(8'h55, 3'b000);
        push(8'h66, 3'b001);
        rd_data_stb = 1'b1;
        status_read("R5", 8'h81);
        rd_data_stb = 1'b0;
        check("R5", "tag set wins over read", status_out, 8'h85);
        check("R5", "new head byte", data_out, 8'h66);
        status_read("R4", 8'h85);
        pop();
        check("R6", "summary sticky after last pop", status_out, 8'h80);
        status_read("R6", 8'h80);
        check("R6", "summary clear", status_out, 8'h00);

        // R2/R6: single-holding mode
        do_reset(1'b0);
        push(8'h77, 3'b001);
        check("R6", "no summary in single mode", status_out, 8'h05);
        push(8'h88, 3'b000);
        check("R2", "single capacity overrun", status_out, 8'h07);
        check("R2", "first char kept", data_out, 8'h77);
        pop();
        check("R2", "empty after one pop", status_out, 8'h06);
        check("R2", "data zero when empty", data_out, 8'h00);
        status_read("R4", 8'h06);
        check("R4", "all clear", status_out, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule